// File: doc/BRIEF.md
# Tag Check-Bit Encoder and Error Detector

This block guards a cache tag stored next to six check bits. A write-side encoder turns a 26-bit tag into five Hamming check bits and one bit of overall parity. A read-side detector takes a stored tag and its check bits and computes a syndrome. One clock later it reports a single error, a double error, and a tag error. Tag error means the stored tag itself cannot be trusted, so a hit computed from it must be treated as a miss.

The detector does not correct anything. It can tell whether an error lands in a tag bit or only in a check bit. A flip confined to one check bit is reported as a single error, but it does not raise tag error, so it never forces a false miss.

The code word uses positions 0 to 31. Position 0 holds the overall parity bit. Check bit k sits at position 2^k. Tag bits fill the remaining positions in ascending order, so tag bit 0 is at position 3, tag bit 1 at 5, and so on.

Top module: `tag_ecc_detect`

## Requirements
- R1: For k in 0..4, `wr_check[k]` is the XOR of every tag bit whose code position has bit k set. Tag bit i occupies the i-th position, counted upward from 1, that is not a power of two. `wr_check[5]` makes the XOR of all 32 tag and check bits zero.
- R2: A read whose check bits equal the encoding of its tag produces no flags on the following cycle.
- R3: A read with exactly one tag bit flipped raises `single_err` and `tag_err`, and leaves `double_err` low.
- R4: A read with exactly one check bit flipped, including the overall parity bit `rd_check[5]`, raises `single_err` only. `tag_err` and `double_err` stay low.
- R5: A read with exactly two flipped bits, in any mix of tag and check bits, raises `double_err` and `tag_err`, and leaves `single_err` low. The same flags result if the syndrome points past the last used position.
- R6: `chk_valid` and the flags reflect the read sampled at the previous rising edge. When `rd_valid` was low, `chk_valid` and all flags are low.
- R7: While `rst_n` is low, all registered outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_tag | input | 26 | Tag to encode |
| wr_check | output | 6 | Check bits for wr_tag (combinational) |
| rd_valid | input | 1 | A stored tag is presented for checking |
| rd_tag | input | 26 | Stored tag |
| rd_check | input | 6 | Stored check bits |
| chk_valid | output | 1 | Result of the previous cycle's read |
| single_err | output | 1 | One bit of the word is in error |
| double_err | output | 1 | Uncorrectable error seen |
| tag_err | output | 1 | The stored tag is not trustworthy |

## Verification
A wrong tag-to-position mapping or a wrong decode boundary appears at the ports on the very next cycle, as a flag set on the wrong class of flip. A data flip would then be treated as a harmless check flip, or a check flip would raise `tag_err`. The bench applies every single flip across all 32 bits and a spread of double flips. Each read checks its result exactly one cycle later against a model that classifies the flips by where they were injected, not by any syndrome. A stuck or stale output register shows up as a mismatch on the cycle after an idle or clean read.

// File: rtl/tag_ecc_detect.sv
module tag_ecc_detect #(
  parameter int TAG_W = 26,
  parameter int HAM_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   wr_tag,
  output logic [HAM_W:0]     wr_check,
  input  logic               rd_valid,
  input  logic [TAG_W-1:0]   rd_tag,
  input  logic [HAM_W:0]     rd_check,
  output logic               chk_valid,
  output logic               single_err,
  output logic               double_err,
  output logic               tag_err
);
  localparam int LAST_POS = TAG_W + HAM_W;

  function automatic logic [TAG_W-1:0] cover_mask(input int k);
    logic [TAG_W-1:0] m;
    int n;
    m = '0;
    n = 0;
    for (int q = 1; q <= LAST_POS; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n < TAG_W) m[n] = ((q >> k) & 1) != 0;
        n++;
      end
    end
    return m;
  endfunction

  logic [HAM_W-1:0] wr_ham, syn_lo, rd_enc_ham;
  logic             syn_par;

  for (genvar k = 0; k < HAM_W; k++) begin : g_bit
    assign wr_ham[k]     = ^(wr_tag & cover_mask(k));
    assign syn_lo[k]     = rd_check[k] ^ (^(rd_tag & cover_mask(k)));
    assign rd_enc_ham[k] = ^(rd_tag & cover_mask(k));
  end

  assign wr_check = {(^wr_tag) ^ (^wr_ham), wr_ham};
  assign syn_par  = ^{rd_tag, rd_check};

  logic lo_nz, lo_pow2, lo_beyond;
  logic dec_single, dec_double, dec_tag;

  assign lo_nz      = |syn_lo;
  assign lo_pow2    = (syn_lo & (syn_lo - 1'b1)) == '0;
  assign lo_beyond  = int'(syn_lo) > LAST_POS;
  assign dec_single = syn_par & ~lo_beyond;
  assign dec_double = (~syn_par & lo_nz) | (syn_par & lo_beyond);
  assign dec_tag    = dec_double | (syn_par & ~lo_pow2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      single_err <= 1'b0;
      double_err <= 1'b0;
      tag_err    <= 1'b0;
    end else begin
      chk_valid  <= rd_valid;
      single_err <= rd_valid & dec_single;
      double_err <= rd_valid & dec_double;
      tag_err    <= rd_valid & dec_tag;
    end
  end

  logic rd_clean;
  assign rd_clean = rd_check == {(^rd_tag) ^ (^rd_enc_ham), rd_enc_ham};

  AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_clean |=> !single_err && !double_err && !tag_err); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !chk_valid && !single_err && !double_err && !tag_err); // R6
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> chk_valid); // R6
  AST_DOUBLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    double_err |-> tag_err && !single_err); // R5
  AST_TAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |-> single_err || double_err); // R3
endmodule

// File: tb/tag_ecc_detect_bench.sv
`timescale 1ns/1ps
module tag_ecc_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [25:0] wr_tag = '0, rd_tag = '0;
  logic [5:0]  wr_check, rd_check = '0;
  logic rd_valid = 1'b0;
  logic chk_valid, single_err, double_err, tag_err;
  int checks = 0, errors = 0;
  int pos_tab [26];
  bit done = 0;

  always #4 clk = ~clk;

  tag_ecc_detect u_tag_ecc_detect (
    .clk(clk), .rst_n(rst_n), .wr_tag(wr_tag), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_check(rd_check),
    .chk_valid(chk_valid), .single_err(single_err),
    .double_err(double_err), .tag_err(tag_err));

  function automatic logic [5:0] ref_enc(input logic [25:0] t);
    logic [5:0] c;
    c = '0;
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 26; i++)
        if (((pos_tab[i] >> k) & 1) == 1) c[k] = c[k] ^ t[i];
    c[5] = (^t) ^ (^c[4:0]);
    return c;
  endfunction

  task automatic expect4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,single,double,tag} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic v, input logic [25:0] t, input logic [31:0] flip);
    logic [31:0] word;
    int nflip;
    logic [3:0] exp;
    @(negedge clk);
    word = {ref_enc(t), t} ^ flip;
    rd_valid = v;
    rd_tag   = word[25:0];
    rd_check = word[31:26];
    nflip = $countones(flip);
    if (!v)              exp = 4'b0000;
    else if (nflip == 0) exp = 4'b1000;
    else if (nflip == 1) exp = ((flip[25:0] != '0) ? 4'b1101 : 4'b1100);
    else                 exp = 4'b1011;
    @(posedge clk);
    #1;
    expect4(req, {chk_valid, single_err, double_err, tag_err}, exp);
  endtask

  initial begin
    int n = 0;
    for (int q = 1; q <= 31; q++)
      if ((q & (q - 1)) != 0) begin pos_tab[n] = q; n++; end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [25:0] tags [6];
    tags[0] = 26'h0000000; tags[1] = 26'h3FFFFFF; tags[2] = 26'h2AAAAAA;
    tags[3] = 26'h1555555; tags[4] = 26'h0123456; tags[5] = 26'h3C0FFEE;
    rd_valid = 1'b1;
    rd_check = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    expect4("R7", {chk_valid, single_err, double_err, tag_err}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    rd_valid = 1'b0;

    for (int j = 0; j < 6; j++) begin
      wr_tag = tags[j];
      #1;
      checks++;
      if (wr_check !== ref_enc(tags[j])) begin
        errors++;
        $display("FAIL R1: wr_check actual %h expected %h", wr_check, ref_enc(tags[j]));
      end
    end

    for (int j = 0; j < 6; j++) do_read("R2", 1'b1, tags[j], 32'h0);
    for (int b = 0; b < 26; b++) do_read("R3", 1'b1, tags[b % 6], 32'h1 << b);
    for (int b = 26; b < 32; b++) do_read("R4", 1'b1, tags[b % 6], 32'h1 << b);
    do_read("R6", 1'b0, tags[4], 32'h3);
    do_read("R6", 1'b0, tags[5], 32'h0);
    for (int a = 0; a < 32; a++) begin
      int b2;
      b2 = (a * 7 + 5) % 32;
      if (b2 != a) do_read("R5", 1'b1, tags[a % 6], (32'h1 << a) | (32'h1 << b2));
    end
    do_read("R5", 1'b1, tags[2], (32'h1 << 26) | (32'h1 << 31));
    do_read("R5", 1'b1, tags[3], (32'h1 << 0) | (32'h1 << 1));
    do_read("R5", 1'b1, tags[1], (32'h1 << 25) | (32'h1 << 30));
    do_read("R2", 1'b1, tags[3], 32'h0);
    @(negedge clk);
    rd_valid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule